// File: doc/BRIEF.md
# CSR-Mapped Serial Transmit Register

This block is one 64-bit control/status register on a processor's CSR port. It sits at a single fixed CSR address and turns writes into asynchronous serial frames on one output pin. Software packs the complete frame into the write data: a start flag, the eight character bits and a stop flag, placed in the order the line sends them. A write with the start flag at 1 and the stop flag at 0 launches the frame. A fixed divisor, set by a parameter, gives the length of each bit period in clocks.

Reading the register returns the frame as it leaves the line. The start/character/stop field moves down by one bit position per bit period. Bit 2 of the read value always equals the current line level. Software polls until the value is back at 0x4, and a new character can then be written. Two more bits of the register serve an external harness. One write sets a sticky "done" output, and in the same write it can also set a sticky "failed" output. Both outputs hold until reset.

Top module: `csr_serial_tx`

## Requirements
- R1: Only CSR address 0x0FF selects the register. For any other address `csr_valid` is 0, `csr_rdata` is 0, and a write has no effect on the line, the read value or the sticky outputs.
- R2: `csr_valid` and `csr_rdata` are combinational from the address, in the same cycle as the access. Read data is driven whether `csr_rd_en` is 0 or 1, and a read has no side effect.
- R3: The register layout is: bit 11 start flag, bits 10:3 character (bit 3 = character bit 0), bit 2 stop flag, bit 1 exit, bit 0 fail. Read data bits 63:12 and bits 1:0 are always 0. Write data bits 63:12 are ignored.
- R4: If the register is idle, a write with bit 11 = 1 and bit 2 = 0 starts a frame at the clock edge that samples the write. From that edge, `tx_line` is low for BIT_CLKS clocks.
- R5: The frame on `tx_line` is a low start bit, then character bits 0 to 7, then a high stop bit. Each bit lasts BIT_CLKS clocks, so the frame takes 10*BIT_CLKS clocks. After the frame the line rests high.
- R6: During bit period k (k = 0..9) of a frame, read bits 11:2 equal ((0x800 | char<<3) >> k) with bits 1:0 cleared. Outside a frame the read value is 0x4. Read bit 2 always equals `tx_line`.
- R7: A write with bit 11 = 0, or with bit 2 = 1, sends no character. The line stays high and the read value stays 0x4.
- R8: A write that requests a character while a frame is in progress is ignored, and the frame in progress is not disturbed. This includes the stop-bit period, in which the read value is already 0x4.
- R9: A write with bit 1 (exit) = 1 sets `done_o`. If bit 0 (fail) is 1 in that same write, it also sets `failed_o`. A fail bit written without exit does nothing. Both outputs stay set until reset.
- R10: A synchronous active-low reset sets `tx_line` high and the read value to 0x4, ends any frame in progress, and clears `done_o` and `failed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_addr | input | 12 | CSR address of the current access |
| csr_rd_en | input | 1 | Read enable; it would gate read side effects, and this register has none |
| csr_wr_en | input | 1 | Write enable |
| csr_wdata | input | 64 | Write data |
| csr_valid | output | 1 | High when the address selects this register |
| csr_rdata | output | 64 | Read data, zero when the register is not selected |
| tx_line | output | 1 | Serial output, high at rest |
| done_o | output | 1 | Sticky exit status |
| failed_o | output | 1 | Sticky fail status |

## Verification
Directed frames with the characters 0x00, 0xFF and 0x55 cover three cases: a line held low, a line high apart from the start bit, and a line that toggles every period. Any error in bit order or period length therefore shows up on the line or in the read view. Random characters are also sent, some of them with a competing request injected at a random cycle. One directed injection falls in the stop-bit period, which separates "ignore while busy" from "accept when the read value is 0x4". The frames run back to back, so the first possible acceptance after a frame is also exercised. Writes that should send nothing are mixed in: start flag clear, stop flag set, wrong address, and a write of all ones. The exit/fail sequence then shows that fail counts only together with exit and that both outputs stay set.

// File: rtl/csr_tx_pkg.sv
`timescale 1ns/1ps
// Shared layout constants and the decoded write-field type for the serial
// transmit register. Positions here are fixed by the frame ordering that
// software builds, so they are not parameters.
package csr_tx_pkg;
    localparam int CHAR_W    = 8;
    localparam int FRAME_W   = CHAR_W + 2;   // start + char + stop
    localparam int POS_START = 11;
    localparam int POS_CHAR  = 3;
    localparam int POS_STOP  = 2;
    localparam int POS_EXIT  = 1;
    localparam int POS_FAIL  = 0;
    localparam int VIEW_LO   = POS_STOP;     // frame view occupies 11:2

    typedef struct packed {
        logic              start;
        logic [CHAR_W-1:0] ch;
        logic              stop;
        logic              ext;
        logic              fail;
    } wr_fields_t;
endpackage

// File: rtl/csr_tx_decode.sv
`timescale 1ns/1ps
// Address match and write-field unpacking.
// Assumes: purely combinational so the select is valid in the first cycle of
// any CSR access; upper write bits are reserved and not decoded here.
module csr_tx_decode
    import csr_tx_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 'h0FF
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [POS_START:0]    wlow,
    output logic                  sel,
    output logic                  wr_hit,
    output wr_fields_t            fields
);
    // Select on exact address match, and qualify writes with it.
    always_comb begin
        sel          = (addr == CSR_ADDR);
        wr_hit       = sel & wr_en;
        fields.start = wlow[POS_START];
        fields.ch    = wlow[POS_CHAR +: CHAR_W];
        fields.stop  = wlow[POS_STOP];
        fields.ext   = wlow[POS_EXIT];
        fields.fail  = wlow[POS_FAIL];
    end
endmodule

// File: rtl/csr_tx_baud.sv
`timescale 1ns/1ps
// Bit-period divider: emits one tick every BIT_CLKS clocks while run is high.
// Assumes: restart arrives only while run is low (at frame launch), so the
// first period of a frame is a full BIT_CLKS clocks long.
module csr_tx_baud #(
    parameter int BIT_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

    logic [CW-1:0] cnt;

    // Tick on the last clock of each bit period.
    always_comb tick = run && (cnt == LAST);

    // Count clocks inside a bit period; hold at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt <= '0;
        else if (tick)                 cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // The counter never runs past the period length (R5).
    assert_period_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/csr_tx_frame.sv
`timescale 1ns/1ps
// Frame shifter: holds the start/char/stop view, shifts it one place per bit
// period and drives the line from its lowest bit. Because the start flag is 1
// and the stop flag 0, the lowest bit is the line level in every period.
// Assumes: tick comes from a divider that runs while busy is high.
module csr_tx_frame
    import csr_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [CHAR_W-1:0]  ch,
    input  logic               tick,
    output logic [FRAME_W-1:0] view,
    output logic               busy,
    output logic               launch,
    output logic               line
);
    localparam logic [FRAME_W-1:0] IDLE = FRAME_W'(1);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    logic [BW-1:0] bitcnt;

    // Accept a request only when no frame is in flight.
    always_comb begin
        launch = req && !busy;
        line   = view[0];
    end

    // Load, shift and retire the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view   <= IDLE;
            busy   <= 1'b0;
            bitcnt <= '0;
        end else if (launch) begin
            view   <= {1'b1, ch, 1'b0};
            busy   <= 1'b1;
            bitcnt <= '0;
        end else if (busy && tick) begin
            if (bitcnt == LAST_BIT) begin
                busy <= 1'b0;
                view <= IDLE;
            end else begin
                view   <= view >> 1;
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    assert_idle_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> view == IDLE);
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy && !line && view == {1'b1, $past(ch), 1'b0});
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req && !tick |=> $stable(view) && busy);
    assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bitcnt == LAST_BIT |-> line);
endmodule

// File: rtl/csr_tx_status.sv
`timescale 1ns/1ps
// Sticky harness status: done on any exit write, failed when that same write
// carries the fail bit. Assumes: cleared only by reset.
module csr_tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic exit_wr,
    input  logic fail_bit,
    output logic done,
    output logic failed
);
    // Latch exit and fail, holding until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            failed <= 1'b0;
        end else if (exit_wr) begin
            done   <= 1'b1;
            failed <= failed | fail_bit;
        end
    end

    assert_sticky_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    assert_fail_with_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(failed) |-> $past(exit_wr) && $past(fail_bit));
endmodule

// File: rtl/csr_serial_tx.sv
`timescale 1ns/1ps
// CSR-mapped serial transmit register. One CSR address; a write packs
// start/char/stop in line order and launches a frame; reads show the frame
// still leaving the line; exit/fail writes drive sticky harness outputs.
// Assumes: synchronous active-low reset; no read side effects exist.
module csr_serial_tx
    import csr_tx_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 64,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 'h0FF,
    parameter int                BIT_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd_en,
    input  logic              csr_wr_en,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic              csr_valid,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              tx_line,
    output logic              done_o,
    output logic              failed_o
);
    logic               sel, wr_hit, tick, busy, launch;
    wr_fields_t         fields;
    logic [FRAME_W-1:0] view;

    csr_tx_decode #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_dec (
        .addr(csr_addr), .wr_en(csr_wr_en), .wlow(csr_wdata[POS_START:0]),
        .sel(sel), .wr_hit(wr_hit), .fields(fields)
    );

    csr_tx_baud #(.BIT_CLKS(BIT_CLKS)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(launch), .tick(tick)
    );

    csr_tx_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .req(wr_hit && fields.start && !fields.stop), .ch(fields.ch),
        .tick(tick), .view(view), .busy(busy), .launch(launch), .line(tx_line)
    );

    csr_tx_status u_stat (
        .clk(clk), .rst_n(rst_n), .exit_wr(wr_hit && fields.ext),
        .fail_bit(fields.fail), .done(done_o), .failed(failed_o)
    );

    // Drive read data whenever selected; exit and fail read back as zero.
    always_comb begin
        csr_valid = sel;
        csr_rdata = '0;
        if (sel) csr_rdata[VIEW_LO +: FRAME_W] = view;
    end

    assert_rdata_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_valid |-> csr_rdata == '0);
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[DATA_W-1:POS_START+1] == '0 && csr_rdata[POS_EXIT:0] == '0);
    assert_upper_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_en && csr_valid && (|csr_wdata[DATA_W-1:POS_START+1])
        && csr_wdata[POS_START:0] == '0 |=> $stable(done_o) && $stable(failed_o));
    assert_line_matches_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
        csr_valid |-> csr_rdata[POS_STOP] == tx_line);
    assert_read_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd_en && !csr_wr_en |=> $stable(done_o) && $stable(failed_o));
endmodule

// File: tb/csr_serial_tx_tb.sv
`timescale 1ns/1ps
module csr_serial_tx_tb_top;
    localparam int BIT_CLKS = 16;
    localparam int FRAME_CLKS = 10 * BIT_CLKS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h0FF;
    logic        csr_rd_en = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic        csr_valid, tx_line, done_o, failed_o;
    logic [63:0] csr_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    csr_serial_tx #(.BIT_CLKS(BIT_CLKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd_en(csr_rd_en),
        .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_valid(csr_valid),
        .csr_rdata(csr_rdata), .tx_line(tx_line), .done_o(done_o),
        .failed_o(failed_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected read value in bit period k of a frame carrying ch (R6).
    function automatic logic [63:0] exp_view(input logic [7:0] ch, input int k);
        logic [11:0] f;
        if (k >= 10) return 64'h4;
        f = 12'h800 | (12'(ch) << 3);
        return 64'((f >> k) & 12'hFFC);
    endfunction

    function automatic logic [63:0] tx_word(input logic [7:0] ch);
        return 64'h800 | (64'(ch) << 3);
    endfunction

    // One write cycle; returns at the falling edge after the sampling edge.
    task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr_en = 1'b1;
        @(negedge clk);
        csr_wr_en = 1'b0; csr_addr = 12'h0FF; csr_wdata = '0;
    endtask

    // Launch a frame and check every clock; optionally inject a request.
    task automatic run_frame(input logic [7:0] ch, input int inj_j,
                             input logic [7:0] inj_ch);
        bit injected = 0;
        csr_write(12'h0FF, tx_word(ch));
        for (int j = 0; j <= FRAME_CLKS; j++) begin
            csr_wr_en = 1'b0;
            csr_rd_en = 1'($urandom_range(0, 1));
            #1;
            if (j == 0)
                chk("R4", "line low after launch", 64'(tx_line), 64'(0));
            chk(injected ? "R8" : "R5", "line level", 64'(tx_line),
                64'(exp_view(ch, j / BIT_CLKS) >> 2) & 64'h1);
            chk(injected ? "R8" : "R6", "read view", csr_rdata,
                exp_view(ch, j / BIT_CLKS));
            if (j == inj_j) begin
                csr_wdata = tx_word(inj_ch); csr_wr_en = 1'b1; injected = 1;
            end
            @(negedge clk);
        end
        csr_wr_en = 1'b0; csr_wdata = '0;
    endtask

    // Check the line stays idle for n clocks after a non-sending write.
    task automatic hold_idle(input string req, input int n);
        for (int j = 0; j < n; j++) begin
            #1;
            chk(req, "line idle", 64'(tx_line), 64'(1));
            chk(req, "view idle", csr_rdata, 64'h4);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "reset line", 64'(tx_line), 64'(1));
        chk("R10", "reset view", csr_rdata, 64'h4);
        chk("R10", "reset done", 64'(done_o), 64'(0));
        chk("R10", "reset failed", 64'(failed_o), 64'(0));

        // Combinational select and read data, regardless of read enable.
        csr_rd_en = 1'b0; #1;
        chk("R2", "valid rd_en=0", 64'(csr_valid), 64'(1));
        chk("R2", "rdata rd_en=0", csr_rdata, 64'h4);
        csr_addr = 12'h0FE; csr_rd_en = 1'b1; #1;
        chk("R1", "valid other addr", 64'(csr_valid), 64'(0));
        chk("R1", "rdata other addr", csr_rdata, 64'h0);
        csr_addr = 12'h1FF; #1;
        chk("R1", "rdata other addr 2", csr_rdata, 64'h0);
        csr_addr = 12'h0FF; csr_rd_en = 1'b0;

        // Directed frames; two with an injected request.
        run_frame(8'h00, -1, 8'h00);
        run_frame(8'hFF, 9 * BIT_CLKS + 1, 8'h00);   // during stop bit
        run_frame(8'h55, 0, 8'hAA);                  // right after launch

        // Random frames, back to back, some with injected requests.
        for (int n = 0; n < 12; n++) begin
            logic [7:0] c = 8'($urandom());
            int ij = ($urandom_range(0, 2) == 0) ? -1
                     : int'($urandom_range(0, FRAME_CLKS - 2));
            run_frame(c, ij, 8'($urandom()));
        end

        // Writes that must not send anything.
        csr_write(12'h0FF, 64'(8'h41) << 3);                     // start clear
        hold_idle("R7", 3 * BIT_CLKS);
        csr_write(12'h0FF, tx_word(8'h41) | 64'h4);              // stop set
        hold_idle("R7", 3 * BIT_CLKS);
        csr_write(12'h0FE, tx_word(8'h41) | 64'h3);              // wrong addr
        hold_idle("R1", 3 * BIT_CLKS);
        chk("R1", "wrong addr exit ignored", 64'(done_o), 64'(0));
        for (int n = 0; n < 6; n++) begin
            logic [11:0] a = 12'($urandom());
            if (a == 12'h0FF) a = 12'h0F7;
            csr_write(a, tx_word(8'($urandom())) | 64'h2);
            hold_idle("R1", BIT_CLKS);
        end
        chk("R1", "random addr exit ignored", 64'(done_o), 64'(0));

        // Exit and fail status.
        csr_write(12'h0FF, 64'h1);
        chk("R9", "fail alone: done", 64'(done_o), 64'(0));
        chk("R9", "fail alone: failed", 64'(failed_o), 64'(0));
        csr_write(12'h0FF, 64'h2);
        chk("R9", "exit: done", 64'(done_o), 64'(1));
        chk("R9", "exit: failed", 64'(failed_o), 64'(0));
        csr_write(12'h0FF, 64'h0);
        chk("R9", "done sticky", 64'(done_o), 64'(1));
        csr_write(12'h0FF, 64'h3);
        chk("R9", "exit+fail: failed", 64'(failed_o), 64'(1));
        csr_write(12'h0FF, 64'h2);
        chk("R9", "failed sticky", 64'(failed_o), 64'(1));

        // All ones: start and stop both set, so nothing sent; layout zeros.
        csr_write(12'h0FF, '1);
        #1;
        chk("R3", "readback after all-ones", csr_rdata, 64'h4);
        hold_idle("R7", 2 * BIT_CLKS);

        // Reset in the middle of a frame.
        csr_write(12'h0FF, tx_word(8'h0F));
        repeat (3 * BIT_CLKS) @(negedge clk);
        #1;
        chk("R6", "mid-frame view", csr_rdata, exp_view(8'h0F, 3));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "reset mid-frame line", 64'(tx_line), 64'(1));
        chk("R10", "reset mid-frame view", csr_rdata, 64'h4);
        chk("R10", "reset clears done", 64'(done_o), 64'(0));
        chk("R10", "reset clears failed", 64'(failed_o), 64'(0));
        @(negedge clk);
        hold_idle("R10", 2 * BIT_CLKS);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule